// File: doc/BRIEF.md
# Self-Centering Elastic Buffer

This block carries a continuous stream of 16-bit words from an external parallel-input clock domain into an internal word clock domain. Both clocks run at the same nominal rate, but the phase between them is unknown. A word is written on every rising edge of the write clock and read on every rising edge of the read clock. The read clock is the word-rate strobe that also loads the downstream serializer. The buffer never reports full or empty. It places its pointers half a buffer apart and keeps them there.

Centering is armed by a rising edge on the lock input or on the phase-init input, after both are synchronized into the write domain. A reset release with lock already high also arms it. The write pointer jumps to its centered position on the third write-clock edge after the arming edge, so the write clock has several edges to settle first. A write-domain monitor compares the write pointer with a synchronized, lag-compensated copy of the read pointer. When the gap drifts to an edge of the buffer, it raises the phase-error flag. While that flag is seen in the read domain, the read data is forced to zero. The flag can be wired straight to phase-init so that the buffer recovers on its own. Each recentering discards a few words.

Top module: `phase_elastic_buf`

## Requirements
- R1: While rst_ni is low, and after release until the first centering completes, phase_err_o is 1 and rdata_o is 0.
- R2: Suppose lock_i rises between two write-clock edges. phase_err_o stays 1 through the 5th following wclk_i rising edge and is 0 after the 6th. This is the third edge after the synchronized rising edge is detected.
- R3: Suppose lock_i is already high when rst_ni is released between wclk_i edges. This counts as a new lock, and phase_err_o falls after the 6th wclk_i rising edge that follows the release.
- R4: A rising edge on init_i re-arms a centered buffer. phase_err_o is still 0 after the 2nd wclk_i rising edge that follows it and is 1 after the 3rd.
- R5: An init_i pulse lasting two clock periods is honoured. Centering completes and phase_err_o is 0 after the 6th wclk_i rising edge that follows its start.
- R6: Once centered, with equal-rate clocks and a write stream that increments by 1 per word, each new rdata_o equals the previous one plus 1 (mod 2^16). No word is lost or repeated.
- R7: A falling edge on lock_i has no effect. phase_err_o stays 0 and the read stream stays continuous.
- R8: While centered, phase_err_o rises when the estimated pointer gap reaches 1 or less, or 7 or more, out of 8 entries.
- R9: While phase_err_o stays high, rdata_o is 0 from the third read-clock edge onward.
- R10: With init_i driven by phase_err_o and the read clock running slower, each error episode ends by itself within 20 read-clock periods.
- R11: Centering puts the write pointer 4 entries ahead of the estimated read position. With equal clock rates, no phase error follows for at least 40 write-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Parallel-input (write) clock |
| rclk_i | input | 1 | Internal word (read) clock, also the serializer load strobe |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| wdata_i | input | 16 | Word captured on each wclk_i rising edge |
| lock_i | input | 1 | Lock indication; a rising edge requests centering |
| init_i | input | 1 | Phase-init request; a rising edge requests centering |
| rdata_o | output | 16 | Word delivered on each rclk_i rising edge |
| phase_err_o | output | 1 | Not centered, or pointer gap near a collision |

## Verification
The hardest condition to reach from the ports is a gap drift into the hazard band while the buffer is centered, because equal-rate clocks keep the gap steady indefinitely. The bench lengthens the read-clock period by 10 percent, so the write pointer gains one entry roughly every ten read cycles. It also ties init_i to phase_err_o. This produces repeated hazard, re-arm and recenter cycles. During them the bench checks that the flag rises, that the output goes quiet, and that every episode ends.

// File: rtl/ef_pkg.sv
package ef_pkg;
  typedef enum logic [1:0] {
    AL_IDLE   = 2'd0,
    AL_ARMED  = 2'd1,
    AL_LOCKED = 2'd2
  } align_e;
endpackage

// File: rtl/ef_sync.sv
module ef_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/ef_mem.sv
module ef_mem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              wclk_i,
  input  logic [PTR_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) mem_q[waddr_i] <= wdata_i;

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ef_wr_ctrl.sv
module ef_wr_ctrl import ef_pkg::*; #(
  parameter int DEPTH     = 8,
  parameter int CENTER    = 4,
  parameter int SYNC_LAG  = 2,
  parameter int LO_MARK   = 1,
  parameter int HI_MARK   = 7,
  parameter int ARM_EDGES = 3,
  parameter int PTR_W     = $clog2(DEPTH)
) (
  input  logic             wclk_i,
  input  logic             rst_ni,
  input  logic             lock_i,
  input  logic             init_i,
  input  logic [PTR_W-1:0] rgray_i,
  output logic [PTR_W-1:0] waddr_o,
  output logic             phase_err_o
);
  localparam int CNT_W = $clog2(ARM_EDGES + 1);
  localparam logic [PTR_W-1:0] ONE_P    = PTR_W'(1);
  localparam logic [PTR_W-1:0] LAG_P    = PTR_W'(SYNC_LAG);
  localparam logic [PTR_W-1:0] CENTER_P = PTR_W'(CENTER);
  localparam logic [PTR_W-1:0] LO_P     = PTR_W'(LO_MARK);
  localparam logic [PTR_W-1:0] HI_P     = PTR_W'(HI_MARK);
  localparam logic [CNT_W-1:0] ARM_P    = CNT_W'(ARM_EDGES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  // request edge detection (lock at [1], init at [0])
  logic [1:0] req_s, req_d;
  logic       arm;

  ef_sync #(.W(2)) i_req_sync (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .d_i    ({lock_i, init_i}),
    .q_o    (req_s)
  );

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) req_d <= '0;
    else         req_d <= req_s;
  end

  assign arm = |(req_s & ~req_d);

  // read pointer crossing
  logic [PTR_W-1:0] rgray_s, rbin_s;

  ef_sync #(.W(PTR_W)) i_rptr_sync (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .d_i    (rgray_i),
    .q_o    (rgray_s)
  );

  for (genvar g = 0; g < PTR_W; g++) begin : g_g2b
    assign rbin_s[g] = ^(rgray_s >> g);
  end

  // gap estimate, compensated for the synchronizer lag
  logic [PTR_W-1:0] wptr_q, rd_est, sep_est, target;
  align_e           st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             haz_q, center, gap_bad;

  assign rd_est  = rbin_s + LAG_P;
  assign sep_est = wptr_q - rd_est;
  assign target  = rd_est + CENTER_P - ONE_P;
  assign gap_bad = (sep_est <= LO_P) || (sep_est >= HI_P);
  // a fresh request overrides a centering due on the same edge
  assign center  = (st_q == AL_ARMED) && (cnt_q == CNT_ONE) && !arm;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= AL_IDLE;
      cnt_q  <= '0;
      wptr_q <= '0;
      haz_q  <= 1'b0;
    end else begin
      wptr_q <= center ? (rd_est + CENTER_P) : (wptr_q + ONE_P);
      if (arm) begin
        st_q  <= AL_ARMED;
        cnt_q <= ARM_P;
      end else if (st_q == AL_ARMED) begin
        cnt_q <= cnt_q - CNT_ONE;
        if (cnt_q == CNT_ONE) st_q <= AL_LOCKED;
      end
      haz_q <= (st_q == AL_LOCKED) && !arm && gap_bad;
    end
  end

  assign waddr_o     = center ? target : wptr_q;
  assign phase_err_o = (st_q != AL_LOCKED) || haz_q;

  assert_align_after_count_R2: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $rose(st_q == AL_LOCKED) |-> ($past(cnt_q) == CNT_ONE));

  assert_center_lands_R11: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    center |=> ((sep_est == CENTER_P) || (sep_est == CENTER_P - ONE_P)));

  assert_haz_only_locked_R8: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    haz_q |-> $past(st_q == AL_LOCKED));
endmodule

// File: rtl/ef_rd_side.sv
module ef_rd_side #(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 3
) (
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              err_i,
  output logic [PTR_W-1:0]  raddr_o,
  output logic [PTR_W-1:0]  rgray_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [PTR_W-1:0]  rptr_q, rptr_nx, rgray_q;
  logic [DATA_W-1:0] rdata_q;
  logic              err_s;

  ef_sync #(.W(1)) i_err_sync (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .d_i    (err_i),
    .q_o    (err_s)
  );

  assign rptr_nx = rptr_q + PTR_W'(1);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      rgray_q <= '0;
      rdata_q <= '0;
    end else begin
      rptr_q  <= rptr_nx;
      rgray_q <= rptr_nx ^ (rptr_nx >> 1);
      rdata_q <= err_s ? '0 : mem_rdata_i;
    end
  end

  assign raddr_o = rptr_q;
  assign rgray_o = rgray_q;
  assign rdata_o = rdata_q;

  assert_gray_step_R6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ($countones(rgray_q ^ $past(rgray_q)) == 1));

  assert_quiet_R9: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $past(err_s) |-> (rdata_o == '0));
endmodule

// File: rtl/phase_elastic_buf.sv
module phase_elastic_buf #(
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 8,
  parameter int CENTER    = 4,
  parameter int SYNC_LAG  = 2,
  parameter int LO_MARK   = 1,
  parameter int HI_MARK   = 7,
  parameter int ARM_EDGES = 3
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              lock_i,
  input  logic              init_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              phase_err_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [PTR_W-1:0]  waddr, raddr, rgray;
  logic [DATA_W-1:0] mem_rdata;
  logic              err;

  ef_wr_ctrl #(
    .DEPTH(DEPTH), .CENTER(CENTER), .SYNC_LAG(SYNC_LAG),
    .LO_MARK(LO_MARK), .HI_MARK(HI_MARK), .ARM_EDGES(ARM_EDGES), .PTR_W(PTR_W)
  ) i_wr_ctrl (
    .wclk_i      (wclk_i),
    .rst_ni      (rst_ni),
    .lock_i      (lock_i),
    .init_i      (init_i),
    .rgray_i     (rgray),
    .waddr_o     (waddr),
    .phase_err_o (err)
  );

  ef_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) i_mem (
    .wclk_i  (wclk_i),
    .waddr_i (waddr),
    .wdata_i (wdata_i),
    .raddr_i (raddr),
    .rdata_o (mem_rdata)
  );

  ef_rd_side #(.DATA_W(DATA_W), .PTR_W(PTR_W)) i_rd_side (
    .rclk_i      (rclk_i),
    .rst_ni      (rst_ni),
    .mem_rdata_i (mem_rdata),
    .err_i       (err),
    .raddr_o     (raddr),
    .rgray_o     (rgray),
    .rdata_o     (rdata_o)
  );

  assign phase_err_o = err;
endmodule

// File: tb/test_phase_elastic_buf.sv
module test_phase_elastic_buf;
  logic        wclk = 1'b0;
  logic        rclk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] wdata_i = 16'd1;
  logic        lock_i = 1'b0;
  logic        init_drv = 1'b0;
  logic        fb_en = 1'b0;
  logic        init_i;
  logic [15:0] rdata_o;
  logic        phase_err_o;
  int          rhalf = 10;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  assign init_i = fb_en ? phase_err_o : init_drv;

  phase_elastic_buf i_phase_elastic_buf (
    .wclk_i      (wclk),
    .rclk_i      (rclk),
    .rst_ni      (rst_ni),
    .wdata_i     (wdata_i),
    .lock_i      (lock_i),
    .init_i      (init_i),
    .rdata_o     (rdata_o),
    .phase_err_o (phase_err_o)
  );

  always #10 wclk = ~wclk;

  initial begin
    #7;
    forever #(rhalf) rclk = ~rclk;
  end

  initial forever begin
    @(negedge wclk);
    wdata_i <= wdata_i + 16'd1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wedge_chk(input int k, input string tag, input logic exp);
    repeat (k) @(posedge wclk);
    #1 check(phase_err_o == exp, tag, int'(phase_err_o), int'(exp));
  endtask

  task automatic check_stream(input int n, input string tag);
    logic [15:0] prev;
    repeat (12) @(negedge rclk);
    prev = rdata_o;
    for (int i = 0; i < n; i++) begin
      @(negedge rclk);
      check(rdata_o == prev + 16'd1, tag, int'(rdata_o), int'(prev + 16'd1));
      prev = rdata_o;
    end
  endtask

  task automatic t_reset;
    repeat (4) @(negedge wclk);
    check(phase_err_o == 1'b1, "R1 err in reset", int'(phase_err_o), 1);
    check(rdata_o == 16'd0, "R1 data in reset", int'(rdata_o), 0);
    @(negedge wclk) rst_ni = 1'b1;
    repeat (12) @(negedge wclk);
    check(phase_err_o == 1'b1, "R1 err unlocked", int'(phase_err_o), 1);
    check(rdata_o == 16'd0, "R1 data unlocked", int'(rdata_o), 0);
  endtask

  task automatic t_lock_acquire;
    @(negedge wclk) lock_i = 1'b1;
    wedge_chk(5, "R2 before center", 1'b1);
    wedge_chk(1, "R2 at center", 1'b0);
    check_stream(40, "R6 continuity");
  endtask

  task automatic t_hold_center;
    for (int i = 0; i < 40; i++) begin
      @(negedge wclk);
      check(phase_err_o == 1'b0, "R11 no hazard", int'(phase_err_o), 0);
    end
  endtask

  task automatic t_lock_drop;
    @(negedge wclk) lock_i = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge wclk);
      check(phase_err_o == 1'b0, "R7 err after drop", int'(phase_err_o), 0);
    end
    check_stream(20, "R7 stream after drop");
  endtask

  task automatic t_init_pulse;
    @(negedge wclk) init_drv = 1'b1;
    fork
      begin
        repeat (2) @(negedge wclk);
        init_drv = 1'b0;
      end
      begin
        wedge_chk(2, "R4 before arm", 1'b0);
        wedge_chk(1, "R4 armed", 1'b1);
        wedge_chk(2, "R5 still armed", 1'b1);
        wedge_chk(1, "R5 recentered", 1'b0);
      end
    join
    check_stream(20, "R5 stream after init");
  endtask

  task automatic t_reset_locked;
    lock_i = 1'b1;
    @(negedge wclk) rst_ni = 1'b0;
    repeat (3) @(negedge wclk);
    check(phase_err_o == 1'b1, "R1 err reset locked", int'(phase_err_o), 1);
    rst_ni = 1'b1;
    wedge_chk(5, "R3 before center", 1'b1);
    wedge_chk(1, "R3 at center", 1'b0);
    check_stream(20, "R6 stream after reset");
  endtask

  task automatic t_drift;
    int rises = 0;
    int falls = 0;
    int run = 0;
    int longest = 0;
    logic last = 1'b0;
    fb_en = 1'b1;
    rhalf = 11;
    for (int i = 0; i < 900; i++) begin
      @(negedge rclk);
      if (phase_err_o && !last) rises++;
      if (!phase_err_o && last) falls++;
      last = phase_err_o;
      run = phase_err_o ? run + 1 : 0;
      if (run > longest) longest = run;
      if (run == 5) check(rdata_o == 16'd0, "R9 forced zero", int'(rdata_o), 0);
    end
    check(rises >= 3, "R8 hazard raised", rises, 3);
    check(falls >= 3, "R10 recovered", falls, 3);
    check(longest <= 20, "R10 episode length", longest, 20);
  endtask

  initial begin
    t_reset();
    t_lock_acquire();
    t_hold_center();
    t_lock_drop();
    t_init_pulse();
    t_reset_locked();
    t_drift();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule